// File: doc/BRIEF.md
# Set/Clear Maskable Interrupt Controller

This block gathers five single-cycle event strobes into a sticky status register and raises an active-low interrupt request when any pending event is also enabled. The five sources are timer A underflow, timer B underflow, event-counter alarm, serial transfer done, and a falling edge on an external flag pin. The flag pin is asynchronous, so it passes through a synchronizer before its falling edge is detected. The other four strobes are synchronous to `clk`.

Software reaches the block through one byte-wide register address. A read returns the status byte and clears it. A write updates the enable mask. Bit 7 of the written byte chooses whether the marked bits are set or cleared. Only bits written as 1 are affected, so a driver can enable or disable one source without knowing the others.

`rdata_o` shows the status byte continuously. The clear happens on the clock edge of a read access (`sel_i` high, `wr_i` low). `rst_n` is asserted asynchronously and must be released synchronously to `clk`.

Top module: `intc_setclr`

## Requirements
- R1: The read byte is laid out as: bit 0 timer A, bit 1 timer B, bit 2 alarm, bit 3 serial, bit 4 flag, bits 6:5 always 0, bit 7 the summary request bit.
- R2: An event strobe sets its status bit on the next clock edge whether or not that source is enabled in the mask.
- R3: When a status bit and its mask bit are both 1, bit 7 of the read byte is 1 and `irq_n_o` is low. When no such pair exists, bit 7 is 0 and `irq_n_o` is high.
- R4: A read access clears every status bit on its clock edge, so bit 7 and the request line are released from the next cycle.
- R5: On a write access, data bits 4:0 that are 1 set the matching mask bits when data bit 7 is 1, and clear them when data bit 7 is 0. Data bits that are 0, and data bits 6:5, leave the mask unchanged.
- R6: A high-to-low transition on `flag_n_i` sets status bit 4 three clock edges after it is first sampled. A rising edge, or a level held low, sets nothing further.
- R7: An event strobe arriving in the same cycle as a read access leaves its status bit set after that edge. The other bits are cleared.
- R8: After reset, the status and mask registers are 0, `rdata_o` is 0x00 and `irq_n_o` is high.
- R9: A write access never changes the status register; only the request output follows the new mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| tmra_evt_i | input | 1 | Timer A underflow strobe |
| tmrb_evt_i | input | 1 | Timer B underflow strobe |
| alarm_evt_i | input | 1 | Event-counter alarm strobe |
| serial_evt_i | input | 1 | Serial transfer done strobe |
| flag_n_i | input | 1 | Asynchronous flag pin, falling edge is the event |
| sel_i | input | 1 | Register access this cycle |
| wr_i | input | 1 | 1 = mask write, 0 = status read |
| wdata_i | input | 8 | Mask write data |
| rdata_o | output | 8 | Status byte with summary bit |
| irq_n_o | output | 1 | Active-low interrupt request |

## Verification
The embedded assertions check the cycle-by-cycle rules on every clock:
- an event is never lost to a concurrent clear;
- a read with no concurrent event empties the status;
- status bits never drop without a read;
- mask writes touch only the marked bits;
- the request follows an enabled event and drops after a clearing read;
- the detected flag edge lasts one cycle.

Only the bench scenarios show the rest:
- the full byte layout;
- the flag synchronizer latency;
- that rising or steady flag levels are ignored;
- the complete interplay of all 32 mask values with all 32 event patterns.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned NUM_SRC = 5;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned SYNC_N  = 2;

  typedef enum int unsigned {
    SRC_TMRA   = 0,
    SRC_TMRB   = 1,
    SRC_ALARM  = 2,
    SRC_SERIAL = 3,
    SRC_FLAG   = 4
  } src_e;
endpackage

// File: rtl/intc_fall_detect.sv
module intc_fall_detect #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              last_q, last_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], pin_i};
    last_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      last_q <= 1'b1;
    end else begin
      sync_q <= sync_d;
      last_q <= last_d;
    end
  end

  assign fall_o = last_q & ~sync_q[STAGES-1];

  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o); // R6
endmodule

// File: rtl/intc_mask_reg.sv
module intc_mask_reg #(
  parameter int unsigned NUM_SRC = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en_i,
  input  logic               setsel_i,
  input  logic [NUM_SRC-1:0] bits_i,
  output logic [NUM_SRC-1:0] mask_o
);
  logic [NUM_SRC-1:0] mask_q, mask_d;
  logic               mask_en;

  always_comb begin
    mask_en = wr_en_i;
    if (setsel_i) mask_d = mask_q | bits_i;
    else          mask_d = mask_q & ~bits_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  assign mask_o = mask_q;

  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && setsel_i) |=> ((mask_o & $past(bits_i)) == $past(bits_i))); // R5
  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !setsel_i) |=> ((mask_o & $past(bits_i)) == '0)); // R5
  AST_MASK_UNMARKED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> ((mask_o & ~$past(bits_i)) == ($past(mask_o) & ~$past(bits_i)))); // R5
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(mask_o)); // R5
endmodule

// File: rtl/intc_status_reg.sv
module intc_status_reg #(
  parameter int unsigned NUM_SRC = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               clr_i,
  output logic [NUM_SRC-1:0] status_o
);
  logic [NUM_SRC-1:0] status_q, status_d;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    always_comb status_d[i] = evt_i[i] | (status_q[i] & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end

  assign status_o = status_q;

  AST_EVT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((status_o & $past(evt_i)) == $past(evt_i))); // R7
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && evt_i == '0) |=> (status_o == '0)); // R4
  AST_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((status_o & $past(status_o)) == $past(status_o))); // R2
endmodule

// File: rtl/intc_setclr.sv
module intc_setclr
  import intc_pkg::*;
#(
  parameter int unsigned SRC_N = NUM_SRC,
  parameter int unsigned BUS_W = DATA_W,
  parameter int unsigned SYNC  = SYNC_N
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tmra_evt_i,
  input  logic             tmrb_evt_i,
  input  logic             alarm_evt_i,
  input  logic             serial_evt_i,
  input  logic             flag_n_i,
  input  logic             sel_i,
  input  logic             wr_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [BUS_W-1:0] rdata_o,
  output logic             irq_n_o
);
  localparam int unsigned PAD_W = BUS_W - 1 - SRC_N;

  logic             rd_en, wr_en, flag_fall, pending;
  logic [SRC_N-1:0] evt_vec, mask, status;
  logic             unused_wbits;

  assign rd_en = sel_i & ~wr_i;
  assign wr_en = sel_i & wr_i;
  assign unused_wbits = ^wdata_i[BUS_W-2:SRC_N];

  intc_fall_detect #(.STAGES(SYNC)) u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (flag_n_i),
    .fall_o (flag_fall)
  );

  always_comb begin
    evt_vec             = '0;
    evt_vec[SRC_TMRA]   = tmra_evt_i;
    evt_vec[SRC_TMRB]   = tmrb_evt_i;
    evt_vec[SRC_ALARM]  = alarm_evt_i;
    evt_vec[SRC_SERIAL] = serial_evt_i;
    evt_vec[SRC_FLAG]   = flag_fall;
  end

  intc_mask_reg #(.NUM_SRC(SRC_N)) u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en_i  (wr_en),
    .setsel_i (wdata_i[BUS_W-1]),
    .bits_i   (wdata_i[SRC_N-1:0]),
    .mask_o   (mask)
  );

  intc_status_reg #(.NUM_SRC(SRC_N)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_i    (evt_vec),
    .clr_i    (rd_en),
    .status_o (status)
  );

  assign pending = |(status & mask);
  assign rdata_o = {pending, {PAD_W{1'b0}}, status};
  assign irq_n_o = ~pending;

  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(evt_vec & mask)) && !wr_en) |=> !irq_n_o); // R3
  AST_IRQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && evt_vec == '0) |=> (irq_n_o && !rdata_o[BUS_W-1])); // R4
  AST_WRITE_KEEPS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && evt_vec == '0) |=> (rdata_o[SRC_N-1:0] == $past(rdata_o[SRC_N-1:0]))); // R9
endmodule

// File: tb/intc_setclr_bench.sv
`timescale 1ns/1ps
module intc_setclr_bench;
  logic       clk, rst_n;
  logic       tmra, tmrb, alarm, serial, flag_n;
  logic       sel, wr;
  logic [7:0] wdata, rdata;
  logic       irq_n;
  int         n_chk, n_bad;

  intc_setclr u_intc_setclr (
    .clk(clk), .rst_n(rst_n),
    .tmra_evt_i(tmra), .tmrb_evt_i(tmrb), .alarm_evt_i(alarm),
    .serial_evt_i(serial), .flag_n_i(flag_n),
    .sel_i(sel), .wr_i(wr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_n_o(irq_n)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr_mask(input logic [7:0] d);
    sel = 1'b1; wr = 1'b1; wdata = d;
    tick();
    sel = 1'b0; wr = 1'b0; wdata = 8'h00;
  endtask

  task automatic pulse(input logic [3:0] e);
    {serial, alarm, tmrb, tmra} = e;
    tick();
    {serial, alarm, tmrb, tmra} = 4'h0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; {tmra, tmrb, alarm, serial} = 4'h0; flag_n = 1'b1;
    sel = 1'b0; wr = 1'b0; wdata = 8'h00;
    repeat (3) tick();
    chk("R8 rdata in reset", rdata, 8'h00);
    chk("R8 irq in reset", {7'h0, irq_n}, 8'h01);
    rst_n = 1'b1;
    tick();
    chk("R8 rdata after reset", rdata, 8'h00);
    pulse(4'h1);
    chk("R8 mask zero after reset", {7'h0, irq_n}, 8'h01);
    sel = 1'b1; tick(); sel = 1'b0;

    // Sweep every mask value against every event pattern
    for (int m = 0; m < 32; m++) begin
      if (m % 2 == 0) begin
        wr_mask(8'h7F);                   // clear all, bits 6:5 ignored
        wr_mask(8'hE0 | 8'(m));           // set marked
      end else begin
        wr_mask(8'hFF);                   // set all
        wr_mask(8'h60 | 8'(~m & 5'h1F));  // clear unmarked
      end
      for (int p = 0; p < 32; p++) begin
        logic [7:0] exp;
        logic       ir;
        logic [7:0] seen;
        ir  = |(p[4:0] & m[4:0]);
        exp = {ir, 2'b00, p[4:0]};
        flag_n = ~p[4];
        pulse(p[3:0]);
        repeat (3) tick();
        chk("R1 R2 R6 status byte", rdata, exp);
        chk("R3 irq level", {7'h0, irq_n}, {7'h0, ~ir});
        sel = 1'b1; wr = 1'b0;
        seen = rdata;
        flag_n = 1'b1;
        tick();
        sel = 1'b0;
        chk("R4 cleared after read", rdata, 8'h00);
        chk("R4 irq released", {7'h0, irq_n}, 8'h01);
        repeat (4) tick();
        if (p[4]) chk("R6 rising edge ignored", rdata, 8'h00);
        if (seen !== exp) chk("R1 read value", seen, exp);
      end
    end

    // R7: event in same cycle as read survives
    wr_mask(8'h9F);
    pulse(4'h2);
    sel = 1'b1; wr = 1'b0; tmra = 1'b1;
    tick();
    sel = 1'b0; tmra = 1'b0;
    chk("R7 concurrent event kept", rdata, 8'h81);
    sel = 1'b1; tick(); sel = 1'b0;

    // R9: writes leave status untouched
    pulse(4'hC);
    chk("R9 status before write", rdata, 8'h8C);
    wr_mask(8'h1F);
    chk("R9 status kept, mask cleared", rdata, 8'h0C);
    chk("R9 irq follows mask", {7'h0, irq_n}, 8'h01);
    wr_mask(8'h84);
    chk("R9 status kept, alarm enabled", rdata, 8'h8C);
    sel = 1'b1; tick(); sel = 1'b0;

    // R6: flag held low sets once only
    wr_mask(8'h90);
    flag_n = 1'b0;
    repeat (5) tick();
    chk("R6 flag fall sets bit4", rdata, 8'h90);
    sel = 1'b1; tick(); sel = 1'b0;
    repeat (6) tick();
    chk("R6 steady low ignored", rdata, 8'h00);
    flag_n = 1'b1;
    repeat (6) tick();
    chk("R6 rise ignored", rdata, 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule